// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns the 6-bit operand field of a 16-bit, word-addressed processor into a concrete operand location. The location can be a general register, a memory address, the stack pointer, the program counter, the overflow register, or an immediate. Along with the location, the block reports four further things:

- the operand value when it is known without a memory read;
- whether an extension word following the instruction is consumed;
- the stack pointer value that applies after the access;
- whether the location is read-only.

The surrounding core supplies the eight register values, SP, PC, the overflow register and the extension word already fetched from memory. The core also supplies a skip flag. When the skip flag is set, the instruction is being stepped over: no operand is accessed, and the only result the core needs is whether PC must also move past an extension word.

A request is a one-cycle `req_valid` pulse. Every result is registered and appears with `out_valid` on the following cycle. Outside a result cycle, the result outputs keep their last value. Location kinds use the encoding NONE=0, REG=1, MEM=2, SP=3, PC=4, OVF=5, IMM=6. Fields that do not apply to a kind read zero: the memory address for non-memory kinds, the value for memory kinds, and the register select for non-register kinds. All address and stack arithmetic wraps modulo 2^16.

Top module: `operand_decoder`

## Requirements
- R1: Codes 0x00 to 0x07 give kind REG, `reg_sel` equal to the low three code bits (0=A,1=B,2=C,3=X,4=Y,5=Z,6=I,7=J), and the value of that register, with no extension word.
- R2: Codes 0x08 to 0x0F give kind MEM at the address held in the register chosen by the low three code bits, with no extension word.
- R3: Codes 0x10 to 0x17 give kind MEM at (extension word + chosen register) mod 2^16 and set `ext_used`.
- R4: Code 0x18 gives kind MEM at SP, sets `sp_write` and gives `sp_next` = (SP+1) mod 2^16.
- R5: Code 0x19 gives kind MEM at SP, leaves `sp_write` low, and gives `sp_next` = SP.
- R6: Code 0x1A gives kind MEM at (SP-1) mod 2^16, sets `sp_write` and gives `sp_next` equal to that same address.
- R7: Codes 0x1B, 0x1C and 0x1D give kinds SP, PC and OVF respectively, each carrying that register's value, not read-only.
- R8: Code 0x1E gives kind MEM at the extension word. Code 0x1F gives kind IMM with the extension word as its value and is read-only. Both set `ext_used`.
- R9: Codes 0x20 to 0x3F give kind IMM, value (code & 0x1F), `read_only` set and `ext_used` clear. Only IMM results are read-only.
- R10: With `skip` set, the result has kind NONE, zero value and address, `sp_write` and `read_only` clear, and `sp_next` = SP. `ext_used` is still set for codes 0x10 to 0x17, 0x1E and 0x1F.
- R11: Reset clears all outputs. `out_valid` rises exactly one cycle after each `req_valid` and only then. The other outputs change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decode request pulse |
| code | input | 6 | Operand field |
| skip | input | 1 | Instruction is being stepped over |
| regs_flat | input | 128 | Registers A..J, register i at bits [16i+15:16i] |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter |
| ovf_in | input | 16 | Current overflow register |
| next_word | input | 16 | Extension word at PC |
| out_valid | output | 1 | Result valid |
| loc_kind | output | 3 | Location kind (encoding above) |
| reg_sel | output | 3 | Register index for kind REG |
| mem_addr | output | 16 | Address for kind MEM |
| opnd_value | output | 16 | Operand value for non-memory kinds |
| ext_used | output | 1 | Extension word consumed |
| sp_write | output | 1 | SP changes as a side effect |
| sp_next | output | 16 | SP after the access |
| read_only | output | 1 | Writes to this location are discarded |

## Verification
The hardest results to reach from the ports are the wrap corners. One is a push with SP at zero, which must land at 0xFFFF. The others are a pop from 0xFFFF and an indexed address whose sum overflows 16 bits. A random register file seldom produces these values. The stimulus therefore sets SP and the extension word to the exact edge values and replays the stack and indexed codes against them. It also sweeps all 64 codes twice, once with skip clear and once with skip set, so that the skipped extension-word cases are covered. Idle gaps between requests show that the outputs hold their values.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  typedef enum logic [2:0] {
    LK_NONE = 3'd0, LK_REG = 3'd1, LK_MEM = 3'd2, LK_SP = 3'd3,
    LK_PC   = 3'd4, LK_OVF = 3'd5, LK_IMM = 3'd6
  } loc_kind_e;

  typedef enum logic [3:0] {
    M_REG, M_IND, M_IDX, M_POP, M_PEEK, M_PUSH,
    M_SPR, M_PCR, M_OVR, M_XMEM, M_XIMM, M_SHORT
  } mode_e;
endpackage

// File: rtl/opdec_classify.sv
module opdec_classify
  import opdec_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  output mode_e             mode,
  output logic              ext
);
  localparam int SHORT_BIT = CODE_W - 1;

  always_comb begin
    mode = M_REG;
    if (code[SHORT_BIT]) begin
      mode = M_SHORT;
    end else begin
      case (code[4:3])
        2'd0: mode = M_REG;
        2'd1: mode = M_IND;
        2'd2: mode = M_IDX;
        default: begin
          case (code[2:0])
            3'd0: mode = M_POP;
            3'd1: mode = M_PEEK;
            3'd2: mode = M_PUSH;
            3'd3: mode = M_SPR;
            3'd4: mode = M_PCR;
            3'd5: mode = M_OVR;
            3'd6: mode = M_XMEM;
            default: mode = M_XIMM;
          endcase
        end
      endcase
    end
  end

  assign ext = (mode == M_IDX) || (mode == M_XMEM) || (mode == M_XIMM);
endmodule

// File: rtl/opdec_resolve.sv
module opdec_resolve
  import opdec_pkg::*;
#(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int CODE_W = 6
) (
  input  mode_e               mode,
  input  logic [CODE_W-2:0]   code_lo,
  input  logic [NREG*W-1:0]   regs_flat,
  input  logic [W-1:0]        sp_in,
  input  logic [W-1:0]        pc_in,
  input  logic [W-1:0]        ovf_in,
  input  logic [W-1:0]        next_word,
  output loc_kind_e           kind,
  output logic [$clog2(NREG)-1:0] reg_sel,
  output logic [W-1:0]        addr,
  output logic [W-1:0]        value,
  output logic [W-1:0]        sp_next,
  output logic                sp_wr,
  output logic                ro
);
  localparam int RS_W = $clog2(NREG);

  logic [W-1:0] reg_arr [NREG];
  logic [RS_W-1:0] idx;
  logic [W-1:0] chosen, sp_inc, sp_dec;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_arr[g] = regs_flat[g*W +: W];
  end

  assign idx    = code_lo[RS_W-1:0];
  assign chosen = reg_arr[idx];
  assign sp_inc = sp_in + W'(1);
  assign sp_dec = sp_in - W'(1);

  always_comb begin
    kind    = LK_MEM;
    reg_sel = '0;
    addr    = '0;
    value   = '0;
    sp_next = sp_in;
    sp_wr   = 1'b0;
    ro      = 1'b0;
    case (mode)
      M_REG:  begin kind = LK_REG; reg_sel = idx; value = chosen; end
      M_IND:  addr = chosen;
      M_IDX:  addr = next_word + chosen;
      M_POP:  begin addr = sp_in; sp_next = sp_inc; sp_wr = 1'b1; end
      M_PEEK: addr = sp_in;
      M_PUSH: begin addr = sp_dec; sp_next = sp_dec; sp_wr = 1'b1; end
      M_SPR:  begin kind = LK_SP;  value = sp_in;  end
      M_PCR:  begin kind = LK_PC;  value = pc_in;  end
      M_OVR:  begin kind = LK_OVF; value = ovf_in; end
      M_XMEM: addr = next_word;
      M_XIMM: begin kind = LK_IMM; value = next_word; ro = 1'b1; end
      default: begin kind = LK_IMM; value = W'(code_lo); ro = 1'b1; end
    endcase
  end
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
  import opdec_pkg::*;
#(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int CODE_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [CODE_W-1:0]       code,
  input  logic                    skip,
  input  logic [NREG*W-1:0]       regs_flat,
  input  logic [W-1:0]            sp_in,
  input  logic [W-1:0]            pc_in,
  input  logic [W-1:0]            ovf_in,
  input  logic [W-1:0]            next_word,
  output logic                    out_valid,
  output logic [2:0]              loc_kind,
  output logic [$clog2(NREG)-1:0] reg_sel,
  output logic [W-1:0]            mem_addr,
  output logic [W-1:0]            opnd_value,
  output logic                    ext_used,
  output logic                    sp_write,
  output logic [W-1:0]            sp_next,
  output logic                    read_only
);
  localparam int RS_W = $clog2(NREG);

  mode_e           mode;
  logic            ext;
  loc_kind_e       r_kind;
  logic [RS_W-1:0] r_sel;
  logic [W-1:0]    r_addr, r_val, r_spn;
  logic            r_spw, r_ro;

  opdec_classify #(.CODE_W(CODE_W)) u_cls (
    .code(code), .mode(mode), .ext(ext)
  );

  opdec_resolve #(.W(W), .NREG(NREG), .CODE_W(CODE_W)) u_res (
    .mode(mode), .code_lo(code[CODE_W-2:0]), .regs_flat(regs_flat),
    .sp_in(sp_in), .pc_in(pc_in), .ovf_in(ovf_in), .next_word(next_word),
    .kind(r_kind), .reg_sel(r_sel), .addr(r_addr), .value(r_val),
    .sp_next(r_spn), .sp_wr(r_spw), .ro(r_ro)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      loc_kind   <= LK_NONE;
      reg_sel    <= '0;
      mem_addr   <= '0;
      opnd_value <= '0;
      ext_used   <= 1'b0;
      sp_write   <= 1'b0;
      sp_next    <= '0;
      read_only  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        ext_used <= ext;
        if (skip) begin
          loc_kind   <= LK_NONE;
          reg_sel    <= '0;
          mem_addr   <= '0;
          opnd_value <= '0;
          sp_write   <= 1'b0;
          sp_next    <= sp_in;
          read_only  <= 1'b0;
        end else begin
          loc_kind   <= r_kind;
          reg_sel    <= r_sel;
          mem_addr   <= r_addr;
          opnd_value <= r_val;
          sp_write   <= r_spw;
          sp_next    <= r_spn;
          read_only  <= r_ro;
        end
      end
    end
  end
endmodule

// File: rtl/operand_decoder_chk.sv
module operand_decoder_chk #(
  parameter int W = 16,
  parameter int NREG = 8,
  parameter int CODE_W = 6
) (
  input logic clk, rst, req_valid, skip,
  input logic [CODE_W-1:0] code,
  input logic out_valid,
  input logic [2:0] loc_kind,
  input logic [W-1:0] mem_addr,
  input logic ext_used, sp_write, read_only
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(loc_kind) && $stable(mem_addr) && $stable(read_only)));
  a_r9_ro_only_imm: assert property (@(posedge clk) disable iff (rst)
    read_only |-> (loc_kind == 3'd6));
  a_r4_spw_is_mem: assert property (@(posedge clk) disable iff (rst)
    sp_write |-> (loc_kind == 3'd2));
  a_r10_skip_none: assert property (@(posedge clk) disable iff (rst)
    (req_valid && skip) |=> (loc_kind == 3'd0 && !sp_write && !read_only));
  a_r3_idx_ext: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !skip && code[CODE_W-1:3] == 3'b010) |=> (ext_used && loc_kind == 3'd2));
endmodule

bind operand_decoder operand_decoder_chk #(.W(W), .NREG(NREG), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .skip(skip), .code(code),
  .out_valid(out_valid), .loc_kind(loc_kind), .mem_addr(mem_addr),
  .ext_used(ext_used), .sp_write(sp_write), .read_only(read_only)
);

// File: tb/tb_operand_decoder.sv
module tb_operand_decoder;
  logic clk = 0, rst = 1, req_valid = 0, skip = 0;
  logic [5:0] code = 0;
  logic [127:0] regs_flat = 0;
  logic [15:0] sp_in = 0, pc_in = 0, ovf_in = 0, next_word = 0;
  logic out_valid, ext_used, sp_write, read_only;
  logic [2:0] loc_kind, reg_sel;
  logic [15:0] mem_addr, opnd_value, sp_next;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] rv [8];
  logic [31:0] seed = 32'h1234_5678;

  // expected state of the outputs
  logic e_v, e_ext, e_spw, e_ro;
  logic [2:0] e_kind, e_sel;
  logic [15:0] e_addr, e_val, e_spn;
  string e_tag;

  always #4 clk = ~clk;

  operand_decoder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .code(code), .skip(skip),
    .regs_flat(regs_flat), .sp_in(sp_in), .pc_in(pc_in), .ovf_in(ovf_in),
    .next_word(next_word), .out_valid(out_valid), .loc_kind(loc_kind),
    .reg_sel(reg_sel), .mem_addr(mem_addr), .opnd_value(opnd_value),
    .ext_used(ext_used), .sp_write(sp_write), .sp_next(sp_next),
    .read_only(read_only)
  );

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  function automatic string tag_of(int c, bit s);
    if (s) return "R10";
    if (c < 8) return "R1";
    if (c < 16) return "R2";
    if (c < 24) return "R3";
    if (c == 24) return "R4";
    if (c == 25) return "R5";
    if (c == 26) return "R6";
    if (c < 30) return "R7";
    if (c < 32) return "R8";
    return "R9";
  endfunction

  task automatic chk(string t, string f, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, f, act, exp);
    end
  endtask

  task automatic compare_all(string t);
    chk("R11", "out_valid", 16'(out_valid), 16'(e_v));
    chk(t, "loc_kind", 16'(loc_kind), 16'(e_kind));
    chk(t, "reg_sel", 16'(reg_sel), 16'(e_sel));
    chk(t, "mem_addr", mem_addr, e_addr);
    chk(t, "opnd_value", opnd_value, e_val);
    chk(t, "ext_used", 16'(ext_used), 16'(e_ext));
    chk(t, "sp_write", 16'(sp_write), 16'(e_spw));
    chk(t, "sp_next", sp_next, e_spn);
    chk(t, "read_only", 16'(read_only), 16'(e_ro));
  endtask

  // behavioural reference for one request
  task automatic model(int c, bit s);
    e_sel = 0; e_addr = 0; e_val = 0; e_spw = 0; e_ro = 0; e_spn = sp_in;
    e_ext = ((c >= 16 && c < 24) || c == 30 || c == 31);
    e_kind = 2;
    if (s) e_kind = 0;
    else if (c < 8) begin e_kind = 1; e_sel = c[2:0]; e_val = rv[c]; end
    else if (c < 16) e_addr = rv[c-8];
    else if (c < 24) e_addr = 16'((int'(next_word) + int'(rv[c-16])) % 65536);
    else if (c == 24) begin e_addr = sp_in; e_spw = 1; e_spn = 16'((int'(sp_in) + 1) % 65536); end
    else if (c == 25) e_addr = sp_in;
    else if (c == 26) begin e_addr = 16'((int'(sp_in) + 65535) % 65536); e_spw = 1; e_spn = e_addr; end
    else if (c == 27) begin e_kind = 3; e_val = sp_in; end
    else if (c == 28) begin e_kind = 4; e_val = pc_in; end
    else if (c == 29) begin e_kind = 5; e_val = ovf_in; end
    else if (c == 30) e_addr = next_word;
    else if (c == 31) begin e_kind = 6; e_val = next_word; e_ro = 1; end
    else begin e_kind = 6; e_val = 16'(c - 32); e_ro = 1; e_ext = 0; end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic cycle(bit v, int c, bit s);
    req_valid = v; code = 6'(c); skip = s;
    for (int i = 0; i < 8; i++) regs_flat[i*16 +: 16] = rv[i];
    e_v = v;
    if (v) begin model(c, s); e_tag = tag_of(c, s); end
    else e_tag = "R11";
    @(posedge clk);
    @(negedge clk);
    compare_all(e_tag);
  endtask

  task automatic scramble();
    for (int i = 0; i < 8; i++) rv[i] = rnd();
    sp_in = rnd(); pc_in = rnd(); ovf_in = rnd(); next_word = rnd();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rv[i] = 0;
    e_v = 0; e_kind = 0; e_sel = 0; e_addr = 0; e_val = 0;
    e_ext = 0; e_spw = 0; e_spn = 0; e_ro = 0;
    repeat (3) @(negedge clk);
    compare_all("R11");                 // reset state
    rst = 0;
    // full sweep, skip clear, back to back
    for (int c = 0; c < 64; c++) begin scramble(); cycle(1, c, 0); end
    cycle(0, 0, 0);
    cycle(0, 5, 1);                     // idle: outputs hold (R11)
    // full sweep with skip (R10)
    for (int c = 0; c < 64; c++) begin scramble(); cycle(1, c, 1); end
    // wrap corners
    sp_in = 16'h0000; cycle(1, 26, 0);  // R6 push from 0
    sp_in = 16'hFFFF; cycle(1, 24, 0);  // R4 pop from FFFF
    cycle(1, 25, 0);                    // R5 peek
    next_word = 16'hFFFF; rv[2] = 16'h0002; cycle(1, 18, 0); // R3 wrap
    next_word = 16'hFFFF; cycle(1, 31, 0);   // R8 immediate
    cycle(1, 63, 0);                    // R9 max short literal
    cycle(1, 32, 0);                    // R9 zero literal
    // sparse random mix with gaps
    for (int k = 0; k < 200; k++) begin
      logic [15:0] r;
      scramble();
      r = rnd();
      cycle(r[0], int'(r[6:1]), r[7] & r[8]);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule